// File: doc/BRIEF.md
# Decoded Micro-Op Line Cache Lookup

This block keeps a set-associative cache of already-decoded micro-op lines. Each line is keyed by virtual fetch address. A lookup presents a fetch address. In the same cycle the block answers with hit or miss, the way that matched, and the index of the first micro-op to deliver from that way. A front end uses it to skip the legacy decoders whenever a fetch lands on a cached instruction boundary.

The decoder installs lines through a fill port. Each fill describes one contiguous run of instruction bytes inside a 32-byte code window. It gives the run's start offset and length, up to six instruction start offsets each paired with a micro-op index, the micro-op count, and a flag for a microcoded instruction. The block enforces three rules:

- a window may occupy at most three ways;
- ways of one window may not overlap;
- a fetch that lands inside a way but not on an instruction boundary is treated as a conflicting decode.

When any of these rules is broken, every way holding that window is invalidated.

Top module: `uop_line_cache`

## Requirements
- R1: The fetch address splits as byte offset = bits [4:0], set = bits [9:5] and tag = bits [47:10]. A lookup can only hit a valid way in the addressed set whose stored tag equals the address tag. All 8 ways of the set are compared together.
- R2: A lookup hits when the matching way's byte range [start, start+length) contains the offset and the offset equals one of that way's recorded instruction starts. `lk_hit`, `lk_way` (way number 0..7) and `lk_uop` (the micro-op index recorded for that start) are valid combinationally in the cycle of the lookup.
- R3: For any lookup address, at most one way of the set has the offset inside its byte range.
- R4: A lookup whose offset is inside a way's range but is not a recorded start reports a miss. At that clock edge it invalidates every valid way of the set carrying the same tag. Ways of other windows are kept.
- R5: A fill for a window that already holds 3 ways is dropped (`fl_ok` low). At that edge it invalidates all ways of that window.
- R6: A fill whose byte range overlaps a valid way of the same window is dropped. At that edge it invalidates all ways of that window.
- R7: A fill is dropped with no effect on the cache if any of the following holds:
  - its length is 0;
  - start+length exceeds 32;
  - its instruction count is outside 1..6;
  - its micro-op count is outside 1..6;
  - it is flagged microcoded with an instruction count other than 1.
- R8: An accepted fill goes to the lowest-numbered invalid way of its set. If all 8 ways are valid, it goes to the set's replacement pointer. The pointer is 0 after reset and becomes (chosen way + 1) mod 8 after each install.
- R9: A fill to the same set as a lookup in the same cycle is dropped (`fl_ok` low) and leaves the cache unchanged.
- R10: After reset every way is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Lookup virtual fetch address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 3 | Hitting way |
| lk_uop | output | 3 | First micro-op index within the hitting way |
| fl_valid | input | 1 | Fill request |
| fl_addr | input | 48 | Address of the first byte of the run |
| fl_len | input | 6 | Run length in bytes |
| fl_ninsn | input | 3 | Number of instruction starts in the run |
| fl_offs | input | 30 | Start offsets, slot s at bits [5s+4:5s] |
| fl_uidx | input | 18 | Micro-op index per start, slot s at bits [3s+2:3s] |
| fl_nuops | input | 3 | Micro-op count of the run |
| fl_ucode | input | 1 | Run is a single microcoded instruction |
| fl_ok | output | 1 | Fill accepted this cycle |

## Verification
The assertions check, on every cycle, that no two ways claim the lookup offset (R3). They also check that an install never proceeds alongside a same-set lookup (R9). Finally they check that no accepted fill is a multi-instruction microcoded run or a run spilling past its window (R7). What the assertions cannot see is that flushes reach exactly the ways of one window and spare the others (R4 to R6), and that victim choice follows the invalid-first and rotating order (R8). Only the bench scenarios show these, by probing the surviving ways with later lookups.

// File: rtl/uop_line_cache.sv
module uop_line_cache #(
  parameter int ADDR_W  = 48,
  parameter int OFF_W   = 5,
  parameter int SET_W   = 5,
  parameter int WAYS    = 8,
  parameter int SLOTS   = 6,
  parameter int UOPS    = 6,
  parameter int WIN_CAP = 3,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IX_W   = $clog2(UOPS),
  localparam int LEN_W  = OFF_W + 1,
  localparam int SN_W   = $clog2(SLOTS + 1),
  localparam int UN_W   = $clog2(UOPS + 1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [ADDR_W-1:0]     lk_addr,
  output logic                  lk_hit,
  output logic [WAY_W-1:0]      lk_way,
  output logic [IX_W-1:0]       lk_uop,
  input  logic                  fl_valid,
  input  logic [ADDR_W-1:0]     fl_addr,
  input  logic [LEN_W-1:0]      fl_len,
  input  logic [SN_W-1:0]       fl_ninsn,
  input  logic [SLOTS*OFF_W-1:0] fl_offs,
  input  logic [SLOTS*IX_W-1:0] fl_uidx,
  input  logic [UN_W-1:0]       fl_nuops,
  input  logic                  fl_ucode,
  output logic                  fl_ok
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int SUM_W = LEN_W + 1;
  localparam int WIN   = 1 << OFF_W;

  logic [WAYS-1:0]        vld [SETS];
  logic [WAY_W-1:0]       rr  [SETS];
  logic [TAG_W-1:0]       tg  [SETS][WAYS];
  logic [OFF_W-1:0]       st  [SETS][WAYS];
  logic [LEN_W-1:0]       ln  [SETS][WAYS];
  logic [SLOTS-1:0]       sv  [SETS][WAYS];
  logic [SLOTS*OFF_W-1:0] so  [SETS][WAYS];
  logic [SLOTS*IX_W-1:0]  si  [SETS][WAYS];

  logic [SET_W-1:0] l_set, f_set;
  logic [TAG_W-1:0] l_tag, f_tag;
  logic [OFF_W-1:0] l_off, f_st;
  assign l_set = lk_addr[OFF_W +: SET_W];
  assign l_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign l_off = lk_addr[OFF_W-1:0];
  assign f_set = fl_addr[OFF_W +: SET_W];
  assign f_tag = fl_addr[ADDR_W-1 -: TAG_W];
  assign f_st  = fl_addr[OFF_W-1:0];

  logic [WAYS-1:0] l_win, l_rng;
  logic            l_part;

  always_comb begin
    logic          ex;
    logic [IX_W-1:0] ix;
    lk_hit = 1'b0;
    lk_way = '0;
    lk_uop = '0;
    l_part = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      l_win[w] = vld[l_set][w] && tg[l_set][w] == l_tag;
      l_rng[w] = l_win[w] && l_off >= st[l_set][w] &&
                 SUM_W'(l_off) < SUM_W'(st[l_set][w]) + SUM_W'(ln[l_set][w]);
      ex = 1'b0;
      ix = '0;
      for (int s = 0; s < SLOTS; s++)
        if (sv[l_set][w][s] && so[l_set][w][s*OFF_W +: OFF_W] == l_off) begin
          ex = 1'b1;
          ix = si[l_set][w][s*IX_W +: IX_W];
        end
      if (l_rng[w]) begin
        if (ex) begin
          lk_hit = lk_valid;
          lk_way = WAY_W'(w);
          lk_uop = ix;
        end else begin
          l_part = lk_valid;
        end
      end
    end
  end

  logic [WAYS-1:0]  f_win, f_ovl;
  logic [WAY_W:0]   f_cnt;
  logic [WAY_W-1:0] vic;
  logic [SLOTS-1:0] nmask;
  logic f_legal, f_try, f_conf;

  always_comb begin
    f_cnt = '0;
    vic   = rr[f_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      f_win[w] = vld[f_set][w] && tg[f_set][w] == f_tag;
      f_ovl[w] = f_win[w] &&
                 SUM_W'(f_st) < SUM_W'(st[f_set][w]) + SUM_W'(ln[f_set][w]) &&
                 SUM_W'(st[f_set][w]) < SUM_W'(f_st) + SUM_W'(fl_len);
      f_cnt = f_cnt + (WAY_W+1)'(f_win[w]);
      if (!vld[f_set][w]) vic = WAY_W'(w);
    end
    for (int s = 0; s < SLOTS; s++) nmask[s] = SN_W'(s) < fl_ninsn;
  end

  assign f_legal = fl_len != '0 && SUM_W'(f_st) + SUM_W'(fl_len) <= SUM_W'(WIN) &&
                   fl_ninsn != '0 && fl_ninsn <= SN_W'(SLOTS) &&
                   fl_nuops != '0 && fl_nuops <= UN_W'(UOPS) &&
                   !(fl_ucode && fl_ninsn != SN_W'(1));
  assign f_try  = fl_valid && f_legal && !(lk_valid && l_set == f_set);
  assign f_conf = f_try && (|f_ovl || f_cnt >= (WAY_W+1)'(WIN_CAP));
  assign fl_ok  = f_try && !f_conf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        vld[i] <= '0;
        rr[i]  <= '0;
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (l_part && l_win[w]) vld[l_set][w] <= 1'b0;
        if (f_conf && f_win[w]) vld[f_set][w] <= 1'b0;
      end
      if (fl_ok) begin
        vld[f_set][vic] <= 1'b1;
        rr[f_set]       <= vic + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fl_ok) begin
      tg[f_set][vic] <= f_tag;
      st[f_set][vic] <= f_st;
      ln[f_set][vic] <= fl_len;
      sv[f_set][vic] <= nmask;
      so[f_set][vic] <= fl_offs;
      si[f_set][vic] <= fl_uidx;
    end
  end
endmodule

// File: rtl/uop_line_cache_chk.sv
module uop_line_cache_chk #(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 5,
  parameter int SET_W  = 5,
  parameter int WAYS   = 8,
  parameter int LEN_W  = 6,
  parameter int SN_W   = 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              fl_valid,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [LEN_W-1:0]  fl_len,
  input logic [SN_W-1:0]   fl_ninsn,
  input logic              fl_ucode,
  input logic              fl_ok,
  input logic [WAYS-1:0]   l_rng
);
  p_one_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(l_rng) <= 1);

  p_lookup_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fl_valid && lk_addr[OFF_W +: SET_W] == fl_addr[OFF_W +: SET_W]) |-> !fl_ok);

  p_ucode_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ucode && fl_ninsn != SN_W'(1)) |-> !fl_ok);

  p_window_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ok |-> (fl_len != '0 && (LEN_W+1)'(fl_addr[OFF_W-1:0]) + (LEN_W+1)'(fl_len) <= (LEN_W+1)'(1 << OFF_W)));
endmodule

bind uop_line_cache uop_line_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAYS(WAYS), .LEN_W(LEN_W), .SN_W(SN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_len(fl_len), .fl_ninsn(fl_ninsn),
  .fl_ucode(fl_ucode), .fl_ok(fl_ok), .l_rng(l_rng)
);

// File: tb/sim_uop_line_cache.sv
module sim_uop_line_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fl_valid = 1'b0, fl_ucode = 1'b0;
  logic [47:0] lk_addr = '0, fl_addr = '0;
  logic [5:0]  fl_len = '0;
  logic [2:0]  fl_ninsn = '0, fl_nuops = '0;
  logic [29:0] fl_offs = '0;
  logic [17:0] fl_uidx = '0;
  logic        lk_hit, fl_ok;
  logic [2:0]  lk_way, lk_uop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uop_line_cache u0 (.*);

  function automatic logic [47:0] mk(input logic [7:0] t, input logic [4:0] s, input logic [4:0] o);
    return {38'(t), s, o};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic look(input logic [7:0] t, input logic [4:0] s, input logic [4:0] o,
                      input logic eh, input logic [2:0] ew, input logic [2:0] eu, input string r);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = mk(t, s, o);
    #1;
    chk({r, " hit"}, 32'(lk_hit), 32'(eh));
    if (eh) begin
      chk({r, " way"}, 32'(lk_way), 32'(ew));
      chk({r, " uop"}, 32'(lk_uop), 32'(eu));
    end
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [7:0] t, input logic [4:0] s, input logic [4:0] st,
                      input logic [5:0] len, input logic [2:0] n, input logic [29:0] offs,
                      input logic [17:0] ix, input logic [2:0] nu, input logic uc,
                      input logic eok, input string r);
    @(negedge clk);
    fl_valid = 1'b1; fl_addr = mk(t, s, st); fl_len = len; fl_ninsn = n;
    fl_offs = offs; fl_uidx = ix; fl_nuops = nu; fl_ucode = uc;
    #1;
    chk({r, " fl_ok"}, 32'(fl_ok), 32'(eok));
    @(posedge clk);
    #1 fl_valid = 1'b0;
  endtask

  // {tag[7:0], set[4:0], off[4:0], hit, way[2:0], uop[2:0]}
  localparam logic [24:0] TV [9] = '{
    {8'd1, 5'd1, 5'd0,  1'b1, 3'd0, 3'd0},
    {8'd1, 5'd1, 5'd3,  1'b1, 3'd0, 3'd1},
    {8'd1, 5'd1, 5'd5,  1'b1, 3'd0, 3'd3},
    {8'd1, 5'd1, 5'd12, 1'b1, 3'd1, 3'd2},
    {8'd1, 5'd1, 5'd8,  1'b1, 3'd1, 3'd0},
    {8'd2, 5'd1, 5'd4,  1'b1, 3'd2, 3'd0},
    {8'd1, 5'd1, 5'd20, 1'b0, 3'd0, 3'd0},
    {8'd3, 5'd1, 5'd0,  1'b0, 3'd0, 3'd0},
    {8'd1, 5'd2, 5'd0,  1'b0, 3'd0, 3'd0}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(8'd5, 5'd1, 5'd0, 1'b0, 3'd0, 3'd0, "R10 reset miss");
    look(8'd0, 5'd0, 5'd0, 1'b0, 3'd0, 3'd0, "R10 reset miss zero");

    fill(8'd1, 5'd1, 5'd0, 6'd8, 3'd3, {15'd0, 5'd5, 5'd3, 5'd0}, {9'd0, 3'd3, 3'd1, 3'd0}, 3'd4, 1'b0, 1'b1, "R8 fill A");
    fill(8'd1, 5'd1, 5'd8, 6'd10, 3'd2, {20'd0, 5'd12, 5'd8}, {12'd0, 3'd2, 3'd0}, 3'd3, 1'b0, 1'b1, "R8 fill B");
    fill(8'd2, 5'd1, 5'd4, 6'd4, 3'd1, 30'd4, 18'd0, 3'd1, 1'b1, 1'b1, "R7 ucode single ok");

    for (int i = 0; i < 9; i++)
      look(TV[i][24:17], TV[i][16:12], TV[i][11:7], TV[i][6], TV[i][5:3], TV[i][2:0], "R1 R2 table");

    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(8'd3, 5'd1, 5'd0);
    fill(8'd1, 5'd1, 5'd20, 6'd4, 3'd1, 30'd20, 18'd0, 3'd1, 1'b0, 1'b0, "R9 same-set fill");
    lk_valid = 1'b0;
    look(8'd1, 5'd1, 5'd20, 1'b0, 3'd0, 3'd0, "R9 not installed");

    fill(8'd4, 5'd1, 5'd0, 6'd4, 3'd2, {20'd0, 5'd2, 5'd0}, 18'd0, 3'd2, 1'b1, 1'b0, "R7 ucode two insn");
    fill(8'd4, 5'd1, 5'd0, 6'd0, 3'd1, 30'd0, 18'd0, 3'd1, 1'b0, 1'b0, "R7 zero length");
    fill(8'd4, 5'd1, 5'd30, 6'd4, 3'd1, 30'd30, 18'd0, 3'd1, 1'b0, 1'b0, "R7 past window");
    fill(8'd4, 5'd1, 5'd0, 6'd4, 3'd0, 30'd0, 18'd0, 3'd1, 1'b0, 1'b0, "R7 no insn");
    fill(8'd4, 5'd1, 5'd0, 6'd4, 3'd1, 30'd0, 18'd0, 3'd7, 1'b0, 1'b0, "R7 too many uops");
    look(8'd4, 5'd1, 5'd0, 1'b0, 3'd0, 3'd0, "R7 nothing installed");
    look(8'd4, 5'd1, 5'd30, 1'b0, 3'd0, 3'd0, "R7 nothing installed hi");

    fill(8'd1, 5'd1, 5'd6, 6'd4, 3'd1, 30'd6, 18'd0, 3'd1, 1'b0, 1'b0, "R6 overlap dropped");
    look(8'd1, 5'd1, 5'd0, 1'b0, 3'd0, 3'd0, "R6 A flushed");
    look(8'd1, 5'd1, 5'd8, 1'b0, 3'd0, 3'd0, "R6 B flushed");
    look(8'd2, 5'd1, 5'd4, 1'b1, 3'd2, 3'd0, "R6 other window kept");

    fill(8'd1, 5'd1, 5'd0, 6'd2, 3'd1, 30'd0, 18'd0, 3'd1, 1'b0, 1'b1, "R5 fill 1");
    fill(8'd1, 5'd1, 5'd2, 6'd2, 3'd1, 30'd2, 18'd0, 3'd1, 1'b0, 1'b1, "R5 fill 2");
    fill(8'd1, 5'd1, 5'd4, 6'd2, 3'd1, 30'd4, 18'd0, 3'd1, 1'b0, 1'b1, "R5 fill 3");
    look(8'd1, 5'd1, 5'd4, 1'b1, 3'd3, 3'd0, "R8 lowest invalid way");
    fill(8'd1, 5'd1, 5'd6, 6'd2, 3'd1, 30'd6, 18'd0, 3'd1, 1'b0, 1'b0, "R5 fourth dropped");
    look(8'd1, 5'd1, 5'd0, 1'b0, 3'd0, 3'd0, "R5 window flushed");
    look(8'd1, 5'd1, 5'd4, 1'b0, 3'd0, 3'd0, "R5 window flushed 3");
    look(8'd1, 5'd1, 5'd6, 1'b0, 3'd0, 3'd0, "R5 fourth absent");
    look(8'd2, 5'd1, 5'd4, 1'b1, 3'd2, 3'd0, "R5 other window kept");

    fill(8'd1, 5'd1, 5'd0, 6'd8, 3'd2, {20'd0, 5'd4, 5'd0}, {12'd0, 3'd2, 3'd0}, 3'd3, 1'b0, 1'b1, "R4 fill I");
    fill(8'd1, 5'd1, 5'd8, 6'd4, 3'd1, 30'd8, 18'd0, 3'd1, 1'b0, 1'b1, "R4 fill J");
    look(8'd1, 5'd1, 5'd4, 1'b1, 3'd0, 3'd2, "R4 resident");
    look(8'd1, 5'd1, 5'd2, 1'b0, 3'd0, 3'd0, "R4 mid-instruction miss");
    look(8'd1, 5'd1, 5'd0, 1'b0, 3'd0, 3'd0, "R4 I flushed");
    look(8'd1, 5'd1, 5'd8, 1'b0, 3'd0, 3'd0, "R4 J flushed");
    look(8'd2, 5'd1, 5'd4, 1'b1, 3'd2, 3'd0, "R4 other window kept");

    for (int k = 0; k < 8; k++)
      fill(8'(10 + k), 5'd3, 5'd0, 6'd1, 3'd1, 30'd0, 18'(k), 3'd1, 1'b0, 1'b1, "R8 fill set3");
    look(8'd17, 5'd3, 5'd0, 1'b1, 3'd7, 3'd7, "R1 eighth way compared");
    look(8'd13, 5'd3, 5'd0, 1'b1, 3'd3, 3'd3, "R1 middle way");
    fill(8'd18, 5'd3, 5'd0, 6'd1, 3'd1, 30'd0, 18'd0, 3'd1, 1'b0, 1'b1, "R8 full set 1");
    look(8'd18, 5'd3, 5'd0, 1'b1, 3'd0, 3'd0, "R8 rotate to way0");
    look(8'd10, 5'd3, 5'd0, 1'b0, 3'd0, 3'd0, "R8 way0 evicted");
    look(8'd11, 5'd3, 5'd0, 1'b1, 3'd1, 3'd1, "R8 way1 kept");
    fill(8'd19, 5'd3, 5'd0, 6'd1, 3'd1, 30'd0, 18'd0, 3'd1, 1'b0, 1'b1, "R8 full set 2");
    look(8'd19, 5'd3, 5'd0, 1'b1, 3'd1, 3'd0, "R8 rotate to way1");
    look(8'd11, 5'd3, 5'd0, 1'b0, 3'd0, 3'd0, "R8 way1 evicted");

    rst_n = 1'b0;
    #5 rst_n = 1'b1;
    look(8'd19, 5'd3, 5'd0, 1'b0, 3'd0, 3'd0, "R10 miss after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule